// File: doc/BRIEF.md
# Stereo Soft-Mute and Attenuation Gain Stage

This block scales a stream of signed stereo PCM words by a common gain. Pulling the active-low mute control low walks the gain down to silence along a smooth S-shaped curve that approximates a half cosine. Releasing it walks the gain back up through the same curve until the path is an exact pass-through. A second active-low control divides every word by four (12 dB) after the mute gain has been applied.

Both controls are looked at only in the cycle that carries a sample strobe, so a gain or attenuation change always lands on a whole stereo word. Left and right share one gain level, so the two channels never drift apart during a ramp. Results appear one clock after the strobe, rounded and clipped to the sample width.

Top module: `soft_mute_atten`

## Requirements
- R1: With `mute_n` = 0 seen at a strobe while the level is above 0, the gain level moves one step toward 0; the gain at level L is floor(65536·(96·L² − 2·L³)/32768), so level 32 is 65536 (unity) and level 0 is 0. Starting from unity with a constant nonzero input of 500000, the first zero output is the 962nd strobe after the one at which mute was first seen (that one counted as index 0).
- R2: Every level from 31 down to 1 (and from 1 up to 31) is applied to exactly 31 consecutive strobes; a step is taken when the internal hold count is 0, and the count wraps after 31 strobes of movement and clears when no movement is wanted.
- R3: With `mute_n` = 1 seen at a strobe while the level is below 32, the level climbs by the same rule; from full silence the first strobe whose output equals its input is index 962, and at level 32 with `atten_n` = 1 the output equals the input.
- R4: Controls and data are sampled only on cycles where `in_valid` = 1; between strobes `out_valid` is 0 and the output words keep their last value, and control pulses there leave the gain unchanged.
- R5: With `atten_n` = 0 at a strobe, that word is divided by 4 after the mute gain: output = floor((x·g + 2^17) / 2^18); with `atten_n` = 1, output = floor((x·g + 2^15) / 2^16).
- R6: Results are rounded half up as in R5 and clipped to the signed 20-bit range; at unity gain with attenuation, 524287 gives 131072 and −524288 gives −131072.
- R7: If the mute control flips during a ramp, the level continues from its current value and moves one step at a time in the new direction; the strobe at which release is seen still uses the current level.
- R8: Left and right are scaled by the same gain and the same attenuation, so equal inputs give equal outputs.
- R9: Reset (synchronous, active high) sets the level to 32, `out_valid` to 0 and both outputs to 0; outputs appear one clock after their strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe marking a stereo sample on the inputs |
| in_left | input | 20 | Left sample, signed two's complement |
| in_right | input | 20 | Right sample, signed two's complement |
| mute_n | input | 1 | 0 requests a ramp to silence, 1 a ramp to unity |
| atten_n | input | 1 | 0 selects the 12 dB (divide by 4) reduction |
| out_valid | output | 1 | Output words are new this cycle |
| out_left | output | 20 | Scaled left sample |
| out_right | output | 20 | Scaled right sample |

## Verification
The gain level stepping and the attenuation switch can both act on one strobe: the ramp moves to a new coefficient in the same sample that the divide-by-four is turned on or off. The bench provokes this by toggling the attenuation control on a fixed pattern of strobes throughout a full down-ramp, so many toggles coincide with level steps. Every output is compared against a reference model of level, hold count and rounding built from the requirement formulas, and the exact strobe of the first silent and first pass-through word is checked separately.

// File: rtl/sma_pkg.sv
package sma_pkg;

    typedef enum logic [1:0] {
        RAMP_IDLE = 2'd0,
        RAMP_DOWN = 2'd1,
        RAMP_UP   = 2'd2
    } ramp_dir_e;

    // Smooth S-curve gain for level lvl out of steps, scaled by 2**cw.
    // Approximates a raised half-cosine; evaluated at elaboration only.
    function automatic longint ramp_gain(input int lvl, input int steps, input int cw);
        longint l3;
        longint num;
        longint den;
        l3  = longint'(lvl);
        num = (3 * l3 * l3 * longint'(steps)) - (2 * l3 * l3 * l3);
        den = longint'(steps) * longint'(steps) * longint'(steps);
        return (num <<< cw) / den;
    endfunction

    // Clip a signed value into a w-bit two's complement range.
    function automatic longint sat_clip(input longint v, input int w);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -hi - 1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/sma_ramp.sv
module sma_ramp #(
    parameter int STEPS = 32,
    parameter int HOLD  = 31,
    parameter int CW    = 16,
    localparam int LW   = $clog2(STEPS + 1),
    localparam int HW   = $clog2(HOLD + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          mute_n,
    output logic [CW:0]   gain,
    output logic [LW-1:0] level
);
    import sma_pkg::*;

    localparam logic [LW-1:0] TOP_LVL  = LW'(STEPS);
    localparam logic [HW-1:0] HOLD_END = HW'(HOLD - 1);

    logic [LW-1:0] lvl_q;
    logic [HW-1:0] cnt_q;
    ramp_dir_e     dir;
    logic [CW:0]   gain_rom [STEPS+1];

    for (genvar k = 0; k <= STEPS; k++) begin : g_rom
        localparam longint GV = ramp_gain(k, STEPS, CW);
        assign gain_rom[k] = (CW+1)'(GV);
    end

    always_comb begin
        dir = RAMP_IDLE;
        if (!mute_n && lvl_q != '0)
            dir = RAMP_DOWN;
        else if (mute_n && lvl_q != TOP_LVL)
            dir = RAMP_UP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= TOP_LVL;
            cnt_q <= '0;
        end else if (step) begin
            if (dir != RAMP_IDLE) begin
                if (cnt_q == '0)
                    lvl_q <= (dir == RAMP_UP) ? lvl_q + 1'b1 : lvl_q - 1'b1;
                cnt_q <= (cnt_q == HOLD_END) ? '0 : cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign gain  = gain_rom[lvl_q];
    assign level = lvl_q;

    // R2, R7: the level never moves by more than one step per clock
    a_r7_single_step: assert property (@(posedge clk) disable iff (rst)
        (lvl_q != $past(lvl_q)) |->
            ((lvl_q == $past(lvl_q) + 1'b1) || (lvl_q == $past(lvl_q) - 1'b1)));

    // R4: without a strobe the level stays put
    a_r4_no_move_idle: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(lvl_q));

    // R1: a level change always heads where the mute control points
    a_r1_direction: assert property (@(posedge clk) disable iff (rst)
        (step && !mute_n) |=> (lvl_q <= $past(lvl_q)));

endmodule

// File: rtl/sma_chan.sv
module sma_chan #(
    parameter int SW = 20,
    parameter int CW = 16,
    localparam int PW = SW + CW + 2
) (
    input  logic signed [SW-1:0] x,
    input  logic        [CW:0]   gain,
    input  logic                 atten,
    output logic signed [SW-1:0] y
);
    import sma_pkg::*;

    localparam logic signed [PW-1:0] RND_PLAIN = PW'(1) <<< (CW - 1);
    localparam logic signed [PW-1:0] RND_QUART = PW'(1) <<< (CW + 1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] biased;
    logic signed [PW-1:0] shifted;

    always_comb begin
        prod    = PW'(x) * PW'($signed({1'b0, gain}));
        biased  = prod + (atten ? RND_QUART : RND_PLAIN);
        shifted = atten ? (biased >>> (CW + 2)) : (biased >>> CW);
        y       = SW'(sat_clip(longint'(shifted), SW));
    end

endmodule

// File: rtl/soft_mute_atten.sv
module soft_mute_atten #(
    parameter int SW    = 20,
    parameter int CW    = 16,
    parameter int STEPS = 32,
    parameter int HOLD  = 31,
    localparam int NCH  = 2,
    localparam int LW   = $clog2(STEPS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] in_left,
    input  logic signed [SW-1:0] in_right,
    input  logic                 mute_n,
    input  logic                 atten_n,
    output logic                 out_valid,
    output logic signed [SW-1:0] out_left,
    output logic signed [SW-1:0] out_right
);
    localparam logic [CW:0] UNITY = (CW+1)'(1) << CW;

    logic [CW:0]          ramp_gain_w;
    logic [LW-1:0]        ramp_level;
    logic signed [SW-1:0] ch_x [NCH];
    logic signed [SW-1:0] ch_y [NCH];

    assign ch_x[0] = in_left;
    assign ch_x[1] = in_right;

    sma_ramp #(.STEPS(STEPS), .HOLD(HOLD), .CW(CW)) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .step   (in_valid),
        .mute_n (mute_n),
        .gain   (ramp_gain_w),
        .level  (ramp_level)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sma_chan #(.SW(SW), .CW(CW)) u_chan (
            .x     (ch_x[c]),
            .gain  (ramp_gain_w),
            .atten (~atten_n),
            .y     (ch_y[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_left  <= ch_y[0];
                out_right <= ch_y[1];
            end
        end
    end

    // R4: nothing changes at the output between strobes
    a_r4_hold_between: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));

    // R3: full level without attenuation is an exact pass-through
    a_r3_unity_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ramp_gain_w == UNITY && atten_n) |=>
            (out_left == $past(in_left) && out_right == $past(in_right)));

    // R1: the bottom of the ramp is true silence
    a_r1_silent: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ramp_level == '0) |=> (out_left == '0 && out_right == '0));

    // R8: one gain for both channels
    a_r8_matched: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_left == in_right) |=> (out_left == out_right));

endmodule

// File: tb/soft_mute_atten_bench.sv
module soft_mute_atten_bench;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic signed [19:0]  in_left = '0;
    logic signed [19:0]  in_right = '0;
    logic                mute_n = 1'b1;
    logic                atten_n = 1'b1;
    logic                out_valid;
    logic signed [19:0]  out_left;
    logic signed [19:0]  out_right;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;
    int mlvl = 32;
    int mcnt = 0;
    logic signed [19:0] got_l, got_r;

    always #10 clk = ~clk;

    soft_mute_atten u_soft_mute_atten (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .mute_n(mute_n), .atten_n(atten_n),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    typedef struct packed {
        logic               att_n;
        logic signed [19:0] l;
        logic signed [19:0] r;
        logic signed [19:0] el;
        logic signed [19:0] er;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b1, 20'sd1000,   -20'sd1000,  20'sd1000,   -20'sd1000},
        '{1'b0, 20'sd1000,   -20'sd1000,  20'sd250,    -20'sd250},
        '{1'b0, -20'sd7,     20'sd6,      -20'sd2,     20'sd2},
        '{1'b0, 20'sd5,      -20'sd6,     20'sd1,      -20'sd1},
        '{1'b0, 20'sd524287, 20'h80000,   20'sd131072, -20'sd131072},
        '{1'b1, 20'sd524287, 20'h80000,   20'sd524287, 20'h80000},
        '{1'b0, 20'sd2,      -20'sd2,     20'sd1,      20'sd0},
        '{1'b1, 20'sd0,      20'sd1,      20'sd0,      20'sd1}
    };

    function automatic longint gainf(input int lv);
        longint l3 = longint'(lv);
        return (((3 * l3 * l3 * 32) - (2 * l3 * l3 * l3)) * 65536) / 32768;
    endfunction

    function automatic logic signed [19:0] expect_y(input longint x, input int lv, input bit att);
        longint p;
        longint y;
        int sh;
        sh = att ? 18 : 16;
        p = x * gainf(lv);
        y = (p + (longint'(1) <<< (sh - 1))) >>> sh;
        if (y > 524287) y = 524287;
        if (y < -524288) y = -524288;
        return 20'(y);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One strobe; result compared against the reference model.
    task automatic send(input logic signed [19:0] l, input logic signed [19:0] r,
                        input logic m_n, input logic a_n, input string req);
        logic signed [19:0] el, er;
        bit mv;
        @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = r; mute_n = m_n; atten_n = a_n;
        el = expect_y(longint'(l), mlvl, !a_n);
        er = expect_y(longint'(r), mlvl, !a_n);
        mv = m_n ? (mlvl < 32) : (mlvl > 0);
        if (mv) begin
            if (mcnt == 0) mlvl = m_n ? mlvl + 1 : mlvl - 1;
            mcnt = (mcnt == 30) ? 0 : mcnt + 1;
        end else begin
            mcnt = 0;
        end
        @(negedge clk);
        in_valid = 1'b0;
        got_l = out_left;
        got_r = out_right;
        check(out_valid == 1'b1, {req, " out_valid"}, longint'(out_valid), 1);
        check(got_l == el, {req, " left"}, longint'(got_l), longint'(el));
        check(got_r == er, {req, " right"}, longint'(got_r), longint'(er));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            bad++;
            total++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int first;
        logic signed [19:0] hold_l;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check(out_valid == 1'b0, "R9 reset out_valid", longint'(out_valid), 0);
        check(out_left == '0, "R9 reset left", longint'(out_left), 0);
        check(out_right == '0, "R9 reset right", longint'(out_right), 0);

        // R5, R6: vector table at unity level
        foreach (VEC[i]) begin
            send(VEC[i].l, VEC[i].r, 1'b1, VEC[i].att_n, "R5 R6 table");
            check(got_l == VEC[i].el, "R6 table left", longint'(got_l), longint'(VEC[i].el));
            check(got_r == VEC[i].er, "R6 table right", longint'(got_r), longint'(VEC[i].er));
        end

        // R4: control pulses between strobes do nothing
        send(20'sd40000, 20'sd40000, 1'b1, 1'b1, "R4 pre");
        hold_l = got_l;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            mute_n = k[0];
            atten_n = k[1];
            check(out_valid == 1'b0, "R4 idle out_valid", longint'(out_valid), 0);
            check(out_left == hold_l, "R4 idle hold", longint'(out_left), longint'(hold_l));
        end
        send(20'sd40000, 20'sd40000, 1'b1, 1'b1, "R4 post");
        check(got_l == 20'sd40000, "R4 gain untouched", longint'(got_l), 40000);

        // R1, R2, R5: down-ramp with attenuation toggled on a fixed pattern
        first = -1;
        for (int i = 0; i < 1000; i++) begin
            send(20'sd500000, 20'sd500000, 1'b0, (i % 7 == 3) ? 1'b0 : 1'b1, "R1 R2 R5 down-ramp");
            check(got_l == got_r, "R8 channels equal", longint'(got_l), longint'(got_r));
            if (first < 0 && got_l == '0) first = i;
        end
        check(first == 962, "R1 R2 first silent strobe", first, 962);

        // R3: up-ramp from silence
        first = -1;
        for (int i = 0; i < 1000; i++) begin
            send(20'sd300000, -20'sd123456, 1'b1, 1'b1, "R3 up-ramp");
            if (first < 0 && got_l == 20'sd300000) first = i;
        end
        check(first == 962, "R3 first unity strobe", first, 962);
        check(got_r == -20'sd123456, "R3 unity right", longint'(got_r), -123456);

        // R7: release partway into a down-ramp
        for (int i = 0; i < 100; i++)
            send(20'sd200000, 20'sd100000, 1'b0, 1'b1, "R7 partial down");
        send(20'sd200000, 20'sd100000, 1'b1, 1'b1, "R7 release");
        check(got_l == expect_y(200000, 28, 0), "R7 release uses level 28",
              longint'(got_l), longint'(expect_y(200000, 28, 0)));
        for (int i = 0; i < 200; i++)
            send(20'sd200000, 20'sd100000, 1'b1, 1'b1, "R7 climb back");
        check(got_l == 20'sd200000, "R7 back at unity", longint'(got_l), 200000);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule